// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Controller

This block is the slave end of a three-wire serial memory link: chip select, serial clock and data in from a host, and one data out line back to it. It keeps a 128 x 16 register array and decodes seven instructions: read one word, write one word, erase one word, write a pattern to every word, erase the whole array, and set or clear a write-enable latch. All pins are sampled with the system clock. Edges on the serial clock and on chip select are found by comparing each pin with its value one cycle earlier.

An instruction starts with a 1 bit sent while chip select is high. A 2-bit opcode and a 7-bit address follow, and for writes a 16-bit data word comes after that. Instructions that change the array take effect only when chip select falls after a complete frame, and only while the write-enable latch is set. That falling edge also starts a self-timed programming cycle, which is a counter running for a set number of system clocks. If the host raises chip select while the cycle is still running, data out reports busy (0) and then ready (1). A rising serial clock edge with data in high dismisses this status. Instructions that arrive while the cycle runs are ignored.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset the write-enable latch is clear, data out is not driven (do_oe_o = 0, do_o = 0), and every array word reads 16'hFFFF.
- R2: A frame is a start bit of 1, then opcode bits, then 7 address bits, all MSB first and sampled on rising serial clock edges while chip select is high. Opcode 10 is read, 01 is write, 11 is erase, and 00 is extended. For an extended opcode the top two address bits choose 11 enable, 00 disable, 01 write-all, 10 erase-all.
- R3: The enable instruction sets the latch and the disable instruction clears it, each at the chip select fall that ends the frame. While the latch is clear, write, erase, write-all and erase-all leave the array unchanged and start no cycle.
- R4: Write takes 16 data bits MSB first after the address. The word is stored at the chip select fall that ends a complete frame.
- R5: Read drives a 0 on data out right after the last address bit. The 16 data bits follow MSB first, and data out changes after each rising serial clock edge. do_oe_o stays high while chip select is high.
- R6: Erase sets the addressed word to 16'hFFFF and leaves every other word unchanged.
- R7: Erase-all sets every word to 16'hFFFF. Write-all writes its 16-bit pattern into every word.
- R8: A programming cycle lasts PROG_CYCLES system clocks. If chip select is raised during the cycle, data out is driven 0 while busy and 1 once the cycle ends.
- R9: A rising serial clock edge with chip select and data in both high removes the status. do_oe_o then goes low, and status is also removed when chip select falls.
- R10: If chip select is raised only after the cycle has ended, no status is shown.
- R11: Instructions sent during a programming cycle have no effect.
- R12: An instruction is discarded with no effect if chip select falls before its frame is complete, or if a further rising serial clock edge arrives after the frame is complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from host |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out |
| do_oe_o | output | 1 | Data out drive enable; 0 means high impedance |

## Verification
Two functions can act on the same rising serial clock edge: dismissing the status, and detecting the start bit of the next instruction. The bench provokes this by raising chip select during a programming cycle and at once sending a full write to a word it has just programmed. Its first bit is a 1, so that edge must drop the status, and the rest of the frame must be ignored because the cycle is still running. The bench judges the outcome by checking that do_oe_o has dropped and, after the cycle, that a read returns the earlier word.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;
  typedef enum logic [2:0] {
    CMD_NONE, CMD_READ, CMD_WRITE, CMD_ERASE, CMD_WEN, CMD_WDS, CMD_WRALL, CMD_ERAL
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HEAD, ST_DATA, ST_DONE, ST_READ, ST_DROP
  } st_e;

  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] SUB_WDS   = 2'b00;
  localparam logic [1:0] SUB_WRALL = 2'b01;
  localparam logic [1:0] SUB_ERAL  = 2'b10;
  localparam logic [1:0] SUB_WEN   = 2'b11;

  function automatic cmd_e decode_cmd(logic [1:0] opc, logic [1:0] sub);
    cmd_e c;
    case (opc)
      OPC_READ:  c = CMD_READ;
      OPC_WRITE: c = CMD_WRITE;
      OPC_ERASE: c = CMD_ERASE;
      default: begin
        case (sub)
          SUB_WEN:   c = CMD_WEN;
          SUB_WDS:   c = CMD_WDS;
          SUB_WRALL: c = CMD_WRALL;
          default:   c = CMD_ERAL;
        endcase
      end
    endcase
    return c;
  endfunction

  function automatic logic is_prog(cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_ERASE) || (c == CMD_WRALL) || (c == CMD_ERAL);
  endfunction
endpackage

// File: rtl/mw_pin_edges.sv
module mw_pin_edges #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= pin_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_edge
    assign rise_o[g] = pin_i[g] & ~pin_q[g];
    assign fall_o[g] = ~pin_i[g] & pin_q[g];
  end
endmodule

// File: rtl/mw_cmd_shifter.sv
module mw_cmd_shifter
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              di_i,
  input  logic              sk_rise_i,
  input  logic              cs_fall_i,
  input  logic              block_i,
  output logic              exec_o,
  output cmd_e              cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              rd_load_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_step_o,
  output logic              reading_o
);
  localparam int HEAD_W = 2 + ADDR_W;
  localparam int CNT_W  = $clog2(HEAD_W + DATA_W + 1);

  st_e               state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [HEAD_W-1:0] hdr_q;
  logic [DATA_W-1:0] data_q;
  cmd_e              cmd_q;

  logic [HEAD_W-1:0] hdr_next;
  cmd_e              dec_cmd;
  logic              head_last;

  assign hdr_next  = {hdr_q[HEAD_W-2:0], di_i};
  assign dec_cmd   = decode_cmd(hdr_next[HEAD_W-1 -: 2], hdr_next[ADDR_W-1 -: 2]);
  assign head_last = (state_q == ST_HEAD) && (cnt_q == CNT_W'(HEAD_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hdr_q   <= '0;
      data_q  <= '0;
      cmd_q   <= CMD_NONE;
    end else if (!cs_i) begin
      state_q <= ST_IDLE;
    end else if (sk_rise_i) begin
      case (state_q)
        ST_IDLE: if (di_i && !block_i) begin
          state_q <= ST_HEAD;
          cnt_q   <= '0;
        end
        ST_HEAD: begin
          hdr_q <= hdr_next;
          cnt_q <= cnt_q + 1'b1;
          if (head_last) begin
            cmd_q <= dec_cmd;
            cnt_q <= '0;
            case (dec_cmd)
              CMD_READ:            state_q <= ST_READ;
              CMD_WRITE, CMD_WRALL: state_q <= ST_DATA;
              default:             state_q <= ST_DONE;
            endcase
          end
        end
        ST_DATA: begin
          data_q <= {data_q[DATA_W-2:0], di_i};
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DATA_W - 1)) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_DROP;  // clock after a full frame voids it
        default: ;
      endcase
    end
  end

  assign exec_o    = cs_fall_i && (state_q == ST_DONE);
  assign cmd_o     = cmd_q;
  assign addr_o    = hdr_q[ADDR_W-1:0];
  assign data_o    = data_q;
  assign rd_load_o = sk_rise_i && cs_i && head_last && (dec_cmd == CMD_READ);
  assign rd_addr_o = hdr_next[ADDR_W-1:0];
  assign rd_step_o = sk_rise_i && cs_i && (state_q == ST_READ);
  assign reading_o = (state_q == ST_READ);
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int WORDS = 1 << ADDR_W;

  logic [1:0] pin_rise, pin_fall;
  logic sk_rise, cs_rise, cs_fall;

  mw_pin_edges #(.N(2)) u_edges (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({cs_i, sk_i}),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );
  assign sk_rise = pin_rise[0];
  assign cs_rise = pin_rise[1];
  assign cs_fall = pin_fall[1];

  logic              exec_v, rd_load, rd_step, reading, busy, block;
  cmd_e              cmd;
  logic [ADDR_W-1:0] addr, rd_addr;
  logic [DATA_W-1:0] wdata;

  mw_cmd_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_i      (cs_i),
    .di_i      (di_i),
    .sk_rise_i (sk_rise),
    .cs_fall_i (cs_fall),
    .block_i   (block),
    .exec_o    (exec_v),
    .cmd_o     (cmd),
    .addr_o    (addr),
    .data_o    (wdata),
    .rd_load_o (rd_load),
    .rd_addr_o (rd_addr),
    .rd_step_o (rd_step),
    .reading_o (reading)
  );

  logic wel_q, prog_start;
  assign prog_start = exec_v && wel_q && is_prog(cmd);

  mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (prog_start),
    .busy_o  (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            wel_q <= 1'b0;
    else if (exec_v && cmd == CMD_WEN)      wel_q <= 1'b1;
    else if (exec_v && cmd == CMD_WDS)      wel_q <= 1'b0;
  end

  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
    end else if (prog_start) begin
      case (cmd)
        CMD_WRITE: mem_q[addr] <= wdata;
        CMD_ERASE: mem_q[addr] <= '1;
        CMD_WRALL: for (int i = 0; i < WORDS; i++) mem_q[i] <= wdata;
        CMD_ERAL:  for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
        default: ;
      endcase
    end
  end

  // dummy zero in front of the word
  logic [DATA_W:0] rd_sr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_sr_q <= '0;
    else if (rd_load) rd_sr_q <= {1'b0, mem_q[rd_addr]};
    else if (rd_step) rd_sr_q <= {rd_sr_q[DATA_W-1:0], 1'b0};
  end

  logic armed_q, show_q, clear_edge;
  assign clear_edge = sk_rise && cs_i && di_i && show_q;
  assign block      = busy || show_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      show_q  <= 1'b0;
    end else begin
      if (prog_start)             armed_q <= 1'b1;
      else if (cs_rise || !busy)  armed_q <= 1'b0;
      if (cs_fall || clear_edge)  show_q  <= 1'b0;
      else if (cs_rise && armed_q && busy) show_q <= 1'b1;
    end
  end

  always_comb begin
    do_oe_o = cs_i && (show_q || reading);
    if (!cs_i)       do_o = 1'b0;
    else if (show_q) do_o = ~busy;
    else if (reading) do_o = rd_sr_q[DATA_W];
    else             do_o = 1'b0;
  end
endmodule

// File: rtl/mw_eeprom_checker.sv
module mw_eeprom_checker
  import mw_eeprom_pkg::*;
#(
  parameter int PROG_CYCLES = 1000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_i,
  input logic do_o,
  input logic do_oe_o,
  input logic busy,
  input logic wel,
  input logic exec_v,
  input cmd_e cmd
);
  localparam int CW = $clog2(PROG_CYCLES + 2);
  logic [CW-1:0] busy_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   busy_run_q <= '0;
    else if (busy) busy_run_q <= busy_run_q + 1'b1;
    else           busy_run_q <= '0;
  end

  p_cycle_needs_latch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wel));

  p_cycle_after_cs_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> ($past(!cs_i) && $past(cs_i, 2)));

  p_busy_reads_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && do_oe_o) |-> !do_o);

  p_disable_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_v && cmd == CMD_WDS) |=> !wel);

  p_locked_no_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_v && !wel && !busy) |=> !busy);

  p_cycle_length_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_run_q <= CW'(PROG_CYCLES));
endmodule

bind mw_eeprom_slave mw_eeprom_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_i    (cs_i),
  .do_o    (do_o),
  .do_oe_o (do_oe_o),
  .busy    (busy),
  .wel     (wel_q),
  .exec_v  (exec_v),
  .cmd     (cmd)
);

// File: tb/mw_eeprom_slave_test.sv
module mw_eeprom_slave_test;
  localparam int PROG = 200;
  localparam int K_RD = 0, K_WR = 1, K_ER = 2, K_WEN = 3, K_WDS = 4, K_WRALL = 5, K_ERAL = 6;

  typedef struct packed {
    logic [2:0]  kind;
    logic [6:0]  addr;
    logic [15:0] data;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{3'(K_RD),    7'd5,   16'hFFFF},
    '{3'(K_WR),    7'd5,   16'h1234},
    '{3'(K_RD),    7'd5,   16'hFFFF},
    '{3'(K_WEN),   7'd0,   16'h0000},
    '{3'(K_WR),    7'd5,   16'hA55A},
    '{3'(K_RD),    7'd5,   16'hA55A},
    '{3'(K_WR),    7'd127, 16'h0F0F},
    '{3'(K_RD),    7'd127, 16'h0F0F},
    '{3'(K_ER),    7'd5,   16'h0000},
    '{3'(K_RD),    7'd5,   16'hFFFF},
    '{3'(K_RD),    7'd127, 16'h0F0F},
    '{3'(K_WDS),   7'd0,   16'h0000},
    '{3'(K_WR),    7'd127, 16'h1111},
    '{3'(K_RD),    7'd127, 16'h0F0F},
    '{3'(K_WEN),   7'd0,   16'h0000},
    '{3'(K_WRALL), 7'd0,   16'h3C3C},
    '{3'(K_RD),    7'd77,  16'h3C3C},
    '{3'(K_ERAL),  7'd0,   16'h0000},
    '{3'(K_RD),    7'd0,   16'hFFFF},
    '{3'(K_RD),    7'd127, 16'hFFFF}
  };

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_w, do_oe;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  mw_eeprom_slave #(.PROG_CYCLES(PROG)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_w), .do_oe_o(do_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cs_set(input logic v);
    cs = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    di = b;
    sk = 1'b1;
    repeat (2) @(negedge clk);
    sk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_head(input logic [1:0] opc, input logic [6:0] a);
    bit_out(1'b1);
    for (int i = 1; i >= 0; i--) bit_out(opc[i]);
    for (int i = 6; i >= 0; i--) bit_out(a[i]);
  endtask

  task automatic send_data(input logic [15:0] d, input int nbits);
    for (int i = 15; i > 15 - nbits; i--) bit_out(d[i]);
  endtask

  task automatic wait_prog();
    repeat (PROG + 10) @(negedge clk);
  endtask

  task automatic do_read(input logic [6:0] a, output logic [15:0] v);
    cs_set(1'b1);
    send_head(2'b10, a);
    chk("R5 dummy bit", {30'd0, do_oe, do_w}, 32'h2);
    v = '0;
    for (int i = 15; i >= 0; i--) begin
      bit_out(1'b0);
      v[i] = do_w;
    end
    cs_set(1'b0);
  endtask

  task automatic run_vec(input vec_t v);
    logic [15:0] r;
    case (int'(v.kind))
      K_RD: begin
        do_read(v.addr, r);
        chk("table read R1 R3 R4 R6 R7", {16'd0, r}, {16'd0, v.data});
      end
      K_WR:    begin cs_set(1); send_head(2'b01, v.addr); send_data(v.data, 16); cs_set(0); wait_prog(); end
      K_ER:    begin cs_set(1); send_head(2'b11, v.addr); cs_set(0); wait_prog(); end
      K_WEN:   begin cs_set(1); send_head(2'b00, 7'b1100000); cs_set(0); end
      K_WDS:   begin cs_set(1); send_head(2'b00, 7'b0000000); cs_set(0); end
      K_WRALL: begin cs_set(1); send_head(2'b00, 7'b0100000); send_data(v.data, 16); cs_set(0); wait_prog(); end
      default: begin cs_set(1); send_head(2'b00, 7'b1000000); cs_set(0); wait_prog(); end
    endcase
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reset outputs", {30'd0, do_oe, do_w}, 32'h0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R8 and R9: status while busy, then ready, then dismissed
    cs_set(1); send_head(2'b01, 7'd9); send_data(16'h5AA5, 16); cs_set(0);
    @(negedge clk);
    cs_set(1);
    chk("R8 busy status", {30'd0, do_oe, do_w}, 32'h2);
    repeat (PROG) @(negedge clk);
    chk("R8 ready status", {30'd0, do_oe, do_w}, 32'h3);
    bit_out(1'b1);
    chk("R9 status cleared", {31'd0, do_oe}, 32'h0);
    cs_set(0);
    do_read(7'd9, r);
    chk("R4 word stored", {16'd0, r}, 32'h5AA5);

    // R10: cs raised after the cycle has finished
    cs_set(1); send_head(2'b01, 7'd10); send_data(16'h1111, 16); cs_set(0);
    wait_prog();
    cs_set(1);
    chk("R10 no late status", {31'd0, do_oe}, 32'h0);
    cs_set(0);

    // R11 and R9: clear edge doubles as a start bit while busy
    cs_set(1); send_head(2'b01, 7'd10); send_data(16'h2222, 16); cs_set(0);
    cs_set(1);
    chk("R8 status shown before clear", {31'd0, do_oe}, 32'h1);
    send_head(2'b01, 7'd10);
    chk("R9 clear edge while busy", {31'd0, do_oe}, 32'h0);
    send_data(16'h3333, 16); cs_set(0);
    wait_prog();
    do_read(7'd10, r);
    chk("R11 ignored while busy", {16'd0, r}, 32'h2222);

    // R12: frame cut short
    cs_set(1); send_head(2'b01, 7'd12); send_data(16'h4444, 8); cs_set(0);
    cs_set(1);
    chk("R12 short frame no cycle", {31'd0, do_oe}, 32'h0);
    cs_set(0);
    do_read(7'd12, r);
    chk("R12 short frame no write", {16'd0, r}, 32'hFFFF);

    // R12: extra clock after a complete frame
    cs_set(1); send_head(2'b01, 7'd13); send_data(16'hABCD, 16); bit_out(1'b0); cs_set(0);
    cs_set(1);
    chk("R12 extra clock no cycle", {31'd0, do_oe}, 32'h0);
    cs_set(0);
    do_read(7'd13, r);
    chk("R12 extra clock no write", {16'd0, r}, 32'hFFFF);

    // R2 and R6: erase leaves its neighbour alone
    cs_set(1); send_head(2'b11, 7'd9); cs_set(0); wait_prog();
    do_read(7'd9, r);
    chk("R6 erased word", {16'd0, r}, 32'hFFFF);
    do_read(7'd10, r);
    chk("R2 R6 neighbour kept", {16'd0, r}, 32'h2222);

    finish_run();
  end
endmodule